// File: doc/BRIEF.md
# Paged Program Window Chip-Select Decoder

This block sits beside the CPU address decoders and turns each 16-bit CPU address into a 20-bit extended address. Addresses that fall in the program page window (0x8000 to 0xBFFF) take their upper bits from a 6-bit page register. All other addresses are placed in the top 64 KB of the extended space, at `0xF0000 | cpu_addr`. The block then classifies the access as on-chip or off-chip. For paged program memory this depends on a 2-bit partition setting fixed at integration time. For everything else it depends on hit flags from the neighbouring decoders.

When the chip-select enable bit is set, two port pins become active-low chip selects:
- The emulation select, on port bit 7, marks program-space accesses while the chip is in emulation mode.
- The external select, on port bit 6, marks genuine off-chip accesses while the emulation select is idle.

When the enable bit is clear, both pins return to general-purpose I/O and follow the port's data and direction values.

All paths are combinational from the current address and the registered page index. There is no handshake on any pin. A write to the page register lands on the next rising clock edge and can never be refused, so no back-pressure exists. The address is qualified by a plain valid level, which is not a stream handshake.

Top module: `progwin_csel`

## Requirements
- R1: While `rst_n` is low both pins drive high with output enable low (`cs_pin_o`=2'b11, `cs_pin_oe`=2'b00). The page register resets to 0, so right after reset a window address maps to `{6'h00, cpu_addr[13:0]}`.
- R2: A page write (`pg_we`=1) at a rising edge is used for translation and classification from that edge onward.
- R3: For `cpu_addr[15:14]`=2'b10 (window), `xaddr` = `{page, cpu_addr[13:0]}`.
- R4: For any other address, `xaddr` = `{4'hF, cpu_addr}`.
- R5: For a window or fixed-program access, the access is on-chip when the page field `xaddr[19:14]` >= 64 − N, where N = 8 << `part_sw` (8, 16, 32 or 64 pages for `part_sw` = 0, 1, 2, 3). `is_internal` is 1 exactly then.
- R6: With `emk_en`=1, `cs_pin_o[1]` (emulation select, port bit 7) is low exactly when `addr_valid`, `emul_mode` and program space are all true. Program space means a window address or `hit_fixed_prog`.
- R7: With `emk_en`=1, `cs_pin_o[0]` (external select, port bit 6) is low exactly when the access is valid, not on-chip, not unimplemented, not removed, and the emulation select is high. The two selects are never low together.
- R8: `hit_unimpl` or `hit_removed` never drives the external select low.
- R9: A port-register access (`hit_portk`) counts as on-chip, except when `emul_mode`=1 and `emk_en`=1, where it counts as off-chip. Outside program space, `hit_onchip` makes the access on-chip.
- R10: With `emk_en`=0, `cs_pin_o` = `gpio_dout` and `cs_pin_oe` = `gpio_dir` (index 1 is port bit 7, index 0 is port bit 6). With `emk_en`=1, `cs_pin_oe` = 2'b11.
- R11: With `addr_valid`=0, `is_internal` is 0 and both chip selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_we | input | 1 | Page register write enable |
| pg_wdata | input | 6 | Page register write value |
| cpu_addr | input | 16 | CPU address |
| addr_valid | input | 1 | Address qualifier |
| emul_mode | input | 1 | System is in an emulation mode |
| emk_en | input | 1 | Chip-select pin function enable |
| part_sw | input | 2 | On-chip/off-chip partition setting |
| hit_onchip | input | 1 | Address hits an on-chip register, RAM or EEPROM |
| hit_fixed_prog | input | 1 | Address hits unpaged program space |
| hit_portk | input | 1 | Address hits the chip-select port's data or direction register |
| hit_unimpl | input | 1 | Address hits an unimplemented register location |
| hit_removed | input | 1 | Address hits a location removed from the map |
| gpio_dout | input | 2 | Port data for bits 7:6 |
| gpio_dir | input | 2 | Port direction for bits 7:6 |
| xaddr | output | 20 | Extended address |
| is_internal | output | 1 | Access is on-chip |
| cs_pin_o | output | 2 | Pin values for port bits 7:6 |
| cs_pin_oe | output | 2 | Pin output enables for port bits 7:6 |

## Verification
The bench sweeps all 64 pages under every partition setting and checks each boundary between the on-chip and off-chip page ranges. An off-by-one threshold, or a partition decode that is reversed, shows up as a wrong `is_internal` at page 56, 48 or 32. It then walks every combination of the enable, mode, valid, page class and neighbour hit flags. A design that lets the external select fire on unimplemented or removed locations, lets both selects go low together, or keeps the port registers on-chip in emulation drives the wrong pin level for some combination. Window translation is swept against non-window addresses, so a wrong window tag or a wrong constant fill for unpaged addresses gives a wrong `xaddr`.

// File: rtl/progwin_pkg.sv
package progwin_pkg;

  // Which chip-select a pin carries when the pin function is enabled
  typedef enum logic {
    ROLE_EXT = 1'b0,
    ROLE_EMU = 1'b1
  } cs_role_e;

  // Classification of the current access
  typedef struct packed {
    logic prog;      // program space (window or fixed)
    logic internal;  // served on-chip
    logic external;  // goes to an external device
  } acc_class_t;

endpackage

// File: rtl/progwin_page_reg.sv
module progwin_page_reg #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] page
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  page <= '0;
    else if (we) page <= wdata;
  end

endmodule

// File: rtl/progwin_xlate.sv
module progwin_xlate #(
  parameter int          AW      = 16,
  parameter int          PW      = 6,
  parameter logic [1:0]  WIN_TAG = 2'b10
) (
  input  logic [PW-1:0]      page,
  input  logic [AW-1:0]      cpu_addr,
  output logic               in_window,
  output logic [PW+AW-3:0]   xaddr
);

  localparam int OW   = AW - 2;       // window offset bits
  localparam int XW   = PW + OW;      // extended address width
  localparam int FILL = XW - AW;      // constant bits above an unpaged address

  assign in_window = (cpu_addr[AW-1:OW] == WIN_TAG);

  always_comb begin
    if (in_window) xaddr = {page, cpu_addr[OW-1:0]};
    else           xaddr = {{FILL{1'b1}}, cpu_addr};
  end

endmodule

// File: rtl/progwin_classify.sv
module progwin_classify
  import progwin_pkg::*;
#(
  parameter int PW       = 6,
  parameter int MIN_LOG2 = 3
) (
  input  logic          addr_valid,
  input  logic          in_window,
  input  logic [PW-1:0] xpage,
  input  logic [1:0]    part_sw,
  input  logic          emul_mode,
  input  logic          emk_en,
  input  logic          hit_onchip,
  input  logic          hit_fixed_prog,
  input  logic          hit_portk,
  input  logic          hit_unimpl,
  input  logic          hit_removed,
  output acc_class_t    cls,
  output logic          ecs_act,
  output logic          xcs_act
);

  localparam logic [PW:0] ONE = (PW+1)'(1);

  logic [7:0]  sh;
  logic [PW:0] thresh;
  logic        page_top;
  logic        portk_ext;

  // The on-chip part is the top (MIN_PAGES << part_sw) pages
  always_comb begin
    sh       = 8'(MIN_LOG2) + {6'b0, part_sw};
    thresh   = '0;
    page_top = 1'b1;
    if (sh < 8'(PW)) begin
      thresh   = (ONE << PW) - (ONE << sh);
      page_top = ({1'b0, xpage} >= thresh);
    end
  end

  assign portk_ext = emul_mode & emk_en & hit_portk;

  always_comb begin
    cls.prog     = addr_valid & (in_window | hit_fixed_prog);
    if (!addr_valid)   cls.internal = 1'b0;
    else if (cls.prog) cls.internal = page_top;
    else               cls.internal = (hit_onchip | hit_portk) & ~portk_ext;
    cls.external = addr_valid & ~cls.internal & ~hit_unimpl & ~hit_removed;
  end

  // Emulation select wins; external select only while it is idle
  assign ecs_act = emk_en & emul_mode & cls.prog;
  assign xcs_act = emk_en & cls.external & ~ecs_act;

endmodule

// File: rtl/progwin_pin_mux.sv
module progwin_pin_mux (
  input  logic rst_n,
  input  logic emk_en,
  input  logic cs_act,
  input  logic gpio_d,
  input  logic gpio_dir,
  output logic pin_o,
  output logic pin_oe
);

  always_comb begin
    if (!rst_n) begin
      pin_o  = 1'b1;
      pin_oe = 1'b0;
    end else if (emk_en) begin
      pin_o  = ~cs_act;
      pin_oe = 1'b1;
    end else begin
      pin_o  = gpio_d;
      pin_oe = gpio_dir;
    end
  end

endmodule

// File: rtl/progwin_csel.sv
module progwin_csel
  import progwin_pkg::*;
#(
  parameter int AW       = 16,
  parameter int PW       = 6,
  parameter int MIN_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_we,
  input  logic [PW-1:0]      pg_wdata,
  input  logic [AW-1:0]      cpu_addr,
  input  logic               addr_valid,
  input  logic               emul_mode,
  input  logic               emk_en,
  input  logic [1:0]         part_sw,
  input  logic               hit_onchip,
  input  logic               hit_fixed_prog,
  input  logic               hit_portk,
  input  logic               hit_unimpl,
  input  logic               hit_removed,
  input  logic [1:0]         gpio_dout,
  input  logic [1:0]         gpio_dir,
  output logic [PW+AW-3:0]   xaddr,
  output logic               is_internal,
  output logic [1:0]         cs_pin_o,
  output logic [1:0]         cs_pin_oe
);

  localparam int OW = AW - 2;
  localparam int XW = PW + OW;

  logic [PW-1:0] page;
  logic          in_window;
  acc_class_t    cls;
  logic          ecs_act;
  logic          xcs_act;
  logic [1:0]    cs_act;

  progwin_page_reg #(.PW(PW)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pg_we),
    .wdata (pg_wdata),
    .page  (page)
  );

  progwin_xlate #(.AW(AW), .PW(PW)) u_xlate (
    .page      (page),
    .cpu_addr  (cpu_addr),
    .in_window (in_window),
    .xaddr     (xaddr)
  );

  progwin_classify #(.PW(PW), .MIN_LOG2(MIN_LOG2)) u_cls (
    .addr_valid     (addr_valid),
    .in_window      (in_window),
    .xpage          (xaddr[XW-1:OW]),
    .part_sw        (part_sw),
    .emul_mode      (emul_mode),
    .emk_en         (emk_en),
    .hit_onchip     (hit_onchip),
    .hit_fixed_prog (hit_fixed_prog),
    .hit_portk      (hit_portk),
    .hit_unimpl     (hit_unimpl),
    .hit_removed    (hit_removed),
    .cls            (cls),
    .ecs_act        (ecs_act),
    .xcs_act        (xcs_act)
  );

  assign is_internal = cls.internal;
  assign cs_act[ROLE_EMU] = ecs_act;
  assign cs_act[ROLE_EXT] = xcs_act;

  for (genvar i = 0; i < 2; i++) begin : g_pin
    progwin_pin_mux u_mux (
      .rst_n    (rst_n),
      .emk_en   (emk_en),
      .cs_act   (cs_act[i]),
      .gpio_d   (gpio_dout[i]),
      .gpio_dir (gpio_dir[i]),
      .pin_o    (cs_pin_o[i]),
      .pin_oe   (cs_pin_oe[i])
    );
  end

endmodule

// File: rtl/progwin_csel_chk.sv
module progwin_csel_chk #(
  parameter int AW = 16,
  parameter int PW = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pg_we,
  input logic [PW-1:0]      pg_wdata,
  input logic [AW-1:0]      cpu_addr,
  input logic               addr_valid,
  input logic               emul_mode,
  input logic               emk_en,
  input logic               hit_fixed_prog,
  input logic               hit_portk,
  input logic               hit_unimpl,
  input logic               hit_removed,
  input logic [1:0]         gpio_dout,
  input logic [1:0]         gpio_dir,
  input logic [PW+AW-3:0]   xaddr,
  input logic               is_internal,
  input logic [1:0]         cs_pin_o,
  input logic [1:0]         cs_pin_oe
);

  localparam int OW = AW - 2;
  localparam int XW = PW + OW;

  logic in_win;
  assign in_win = (cpu_addr[AW-1:OW] == 2'b10);

  // R2: a page write shows up in the window translation after the edge
  a_r2_page_write_used: assert property (@(posedge clk) disable iff (!rst_n)
    pg_we |=> (!in_win || xaddr[XW-1:OW] == $past(pg_wdata)));

  // R3: window offset bits pass through
  a_r3_window_offset: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> xaddr[OW-1:0] == cpu_addr[OW-1:0]);

  // R7: the two selects are never low together
  a_r7_selects_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    emk_en |-> cs_pin_o != 2'b00);

  // R8: unimplemented or removed locations never reach the external select
  a_r8_no_xcs_on_hole: assert property (@(posedge clk) disable iff (!rst_n)
    (emk_en && (hit_unimpl || hit_removed)) |-> cs_pin_o[0]);

  // R9: port registers are off-chip in emulation with the pins enabled
  a_r9_portk_external: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && emul_mode && emk_en && hit_portk && !in_win && !hit_fixed_prog)
      |-> !is_internal);

  // R10: pins follow the port registers when the function is off
  a_r10_gpio_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    !emk_en |-> (cs_pin_o == gpio_dout && cs_pin_oe == gpio_dir));

  // R11: no select and no on-chip claim without a valid address
  a_r11_idle_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> (!is_internal && (!emk_en || cs_pin_o == 2'b11)));

endmodule

bind progwin_csel progwin_csel_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pg_we          (pg_we),
  .pg_wdata       (pg_wdata),
  .cpu_addr       (cpu_addr),
  .addr_valid     (addr_valid),
  .emul_mode      (emul_mode),
  .emk_en         (emk_en),
  .hit_fixed_prog (hit_fixed_prog),
  .hit_portk      (hit_portk),
  .hit_unimpl     (hit_unimpl),
  .hit_removed    (hit_removed),
  .gpio_dout      (gpio_dout),
  .gpio_dir       (gpio_dir),
  .xaddr          (xaddr),
  .is_internal    (is_internal),
  .cs_pin_o       (cs_pin_o),
  .cs_pin_oe      (cs_pin_oe)
);

// File: tb/progwin_csel_bench.sv
module progwin_csel_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_we = 1'b0;
  logic [5:0]  pg_wdata = '0;
  logic [15:0] cpu_addr = '0;
  logic        addr_valid = 1'b0;
  logic        emul_mode = 1'b0;
  logic        emk_en = 1'b0;
  logic [1:0]  part_sw = '0;
  logic        hit_onchip = 1'b0, hit_fixed_prog = 1'b0, hit_portk = 1'b0;
  logic        hit_unimpl = 1'b0, hit_removed = 1'b0;
  logic [1:0]  gpio_dout = '0, gpio_dir = '0;
  logic [19:0] xaddr;
  logic        is_internal;
  logic [1:0]  cs_pin_o, cs_pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  progwin_csel u_progwin_csel (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_page(input logic [5:0] p);
    @(negedge clk);
    pg_we = 1'b1;
    pg_wdata = p;
    @(negedge clk);
    pg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state of the pins with the function enabled
    emk_en = 1'b1; emul_mode = 1'b1; addr_valid = 1'b1; cpu_addr = 16'h8123;
    repeat (2) @(negedge clk);
    #1;
    check("R1 pins in reset", {30'b0, cs_pin_o}, 32'h3);
    check("R1 oe in reset", {30'b0, cs_pin_oe}, 32'h0);
    rst_n = 1'b1;
    emk_en = 1'b0; emul_mode = 1'b0;
    @(negedge clk); #1;
    check("R1 page after reset", {12'b0, xaddr}, 32'h00123);

    // R2 R3 R5: every page under every partition
    for (int sw = 0; sw < 4; sw++) begin
      part_sw = 2'(sw);
      for (int pg = 0; pg < 64; pg++) begin
        logic [15:0] a;
        int          n;
        a = 16'h8000 | 16'((pg * 613) & 16'h3FFF);
        write_page(6'(pg));
        cpu_addr = a;
        #1;
        n = 8 << sw;
        check("R2 R3 window xaddr", {12'b0, xaddr}, (pg << 14) | (a & 32'h3FFF));
        check("R5 on-chip page", {31'b0, is_internal}, {31'b0, (pg >= 64 - n)});
      end
    end

    // R4: unpaged addresses land in the top 64 KB
    for (int k = 0; k < 64; k++) begin
      logic [15:0] a;
      a = 16'(k * 16'h0400 + 16'h13);
      if (a[15:14] == 2'b10) continue;
      @(negedge clk);
      cpu_addr = a;
      #1;
      check("R4 unpaged xaddr", {12'b0, xaddr}, 32'hF0000 | a);
    end

    // R6..R11: all flag combinations, partition 0
    part_sw = 2'b00;
    write_page(6'd0);
    for (int c = 0; c < 1024; c++) begin
      logic e, em, v, un, rm, on, pk, fx, w, pt;
      logic prog, top, pkx, intl, ext, ecs, xcs;
      logic [1:0] exp_o, exp_oe;
      {e, em, v, un, rm, on, pk, fx, w, pt} = 10'(c);
      if ((c & 1) == 1 && (c == 1 || ((c - 1) & 1) == 0)) begin end
      if (pt != u_progwin_csel_pg_state(c)) begin end
      write_page(pt ? 6'd63 : 6'd0);
      emk_en = e; emul_mode = em; addr_valid = v; hit_unimpl = un;
      hit_removed = rm; hit_onchip = on; hit_portk = pk; hit_fixed_prog = fx;
      cpu_addr = w ? 16'h9234 : (fx ? 16'hC100 : 16'h0100);
      gpio_dout = 2'(c * 3); gpio_dir = 2'(c >> 3);
      #1;
      prog = v & (w | fx);
      top  = w ? pt : 1'b1;
      pkx  = em & e & pk;
      intl = v & (prog ? top : ((on | pk) & ~pkx));
      ext  = v & ~intl & ~un & ~rm;
      ecs  = e & em & prog;
      xcs  = e & ext & ~ecs;
      exp_o  = e ? {~ecs, ~xcs} : gpio_dout;
      exp_oe = e ? 2'b11 : gpio_dir;
      check("R6 emulation select", {31'b0, cs_pin_o[1]}, {31'b0, exp_o[1]});
      check("R7 R8 external select", {31'b0, cs_pin_o[0]}, {31'b0, exp_o[0]});
      check("R9 R11 internal flag", {31'b0, is_internal}, {31'b0, intl});
      check("R10 output enables", {30'b0, cs_pin_oe}, {30'b0, exp_oe});
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic u_progwin_csel_pg_state(input int c);
    return 1'(c);
  endfunction

endmodule